// File: doc/BRIEF.md
# Twelve-Pin Configurable GPIO Controller

This block controls a bank of general-purpose pins behind a small register port. Each pin has its own configuration word that chooses direction, pull resistor, interrupt edge mode, polarity, driver type (push-pull or open drain), pad enable and a pin function code. A shared level register drives the pins that act as outputs and reports the filtered state of every pin.

On the pad side each pin offers an output value, an output enable, pull-up and pull-down requests, and receives the pad input. The pad input is synchronised and then debounced by a per-pin counter that advances on a shared sample tick. A new level is accepted only after a set number of consecutive ticks that all disagree with the current level. Edges of the debounced level set sticky per-pin status bits, which are cleared by writing ones. The single interrupt output is high while any status bit is set.

The polarity bit does two jobs. It inverts the level seen through the level register, and in single-edge mode it selects which edge raises an interrupt.

Top module: `gpio_bank`

## Requirements
- R1: After reset every configuration word reads 0x0530 (function 0, input, pull-down, single-edge mode, non-inverted, push-pull, enabled). No pad is driven, every pull-down request is high, no pull-up request is high, and irq is low.
- R2: Address k-1 holds the configuration word of pin k (k = 1..NUM_PINS), address NUM_PINS holds the level register (bit k-1 for pin k) and address NUM_PINS+1 holds the interrupt status. Configuration word bits: [3:0] function, [4] direction, [6:5] pull, [7] edge mode, [8] polarity, [9] driver type, [10] enable.
- R3: A pin drives its pad (pad_oe high) only when the function is 0, the direction bit is 0 (1 means input) and the enable bit is 1. With any other function or with direction 1 the pad is released.
- R4: The pad target level is the written level bit when polarity is 1 and its complement when polarity is 0. With driver type 0 (push-pull) the pad is driven to the target. With driver type 1 (open drain) the pad is driven low for target 0 and released for target 1, and it is never driven high.
- R5: Pull field 01 raises pad_pd only, 10 raises pad_pu only, and 00 and the reserved 11 raise neither.
- R6: With the enable bit 0 the pad is released and the pin's bit in the level register reads 0.
- R7: The debounced level changes only on a sample tick, and only after DB_LEN consecutive ticks whose synchronised sample differs from it. Shorter pulses leave it unchanged.
- R8: A pin's bit in the level register equals its debounced pad level when polarity is 1 and the complement when polarity is 0. This applies to inputs and to outputs.
- R9: With edge mode 0 a rising debounced edge sets the pin's status bit when polarity is 1, and a falling edge sets it when polarity is 0. With edge mode 1 both edges set it.
- R10: Status bits stay set until a 1 is written to their position at the status address (writing 0 leaves them). irq is the OR of all status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Debounce sample strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (combinational from address) |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pu | output | NUM_PINS | Pull-up requests |
| pad_pd | output | NUM_PINS | Pull-down requests |
| irq | output | 1 | Interrupt, OR of status bits |

## Verification
The bench builds the block with its default twelve pins, DB_LEN = 4 and two synchroniser stages, and it issues a sample tick every second clock. With that short filter a pulse of five clocks (at most three ticks) falls just under the threshold and must be rejected, while a long hold is accepted within a few tens of cycles. Both sides of the debounce boundary can therefore be checked next to each other. A pad model loops driven outputs back to pad_in and applies the pull requests, so output readback under both polarities and open-drain release are observed at the ports.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int CFG_W = 11;

   typedef struct packed {
      logic       ena;       // [10]
      logic       odrain;    // [9]
      logic       pol;       // [8]
      logic       both_edge; // [7]
      logic [1:0] pull;      // [6:5]
      logic       dir_in;    // [4]
      logic [3:0] func;      // [3:0]
   } pin_cfg_t;

   localparam logic [1:0] PULL_DN = 2'b01;
   localparam logic [1:0] PULL_UP = 2'b10;

   localparam pin_cfg_t CFG_RESET = '{ena: 1'b1, odrain: 1'b0, pol: 1'b1,
                                      both_edge: 1'b0, pull: PULL_DN,
                                      dir_in: 1'b1, func: 4'h0};

endpackage

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
   parameter int DB_LEN      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic raw,
   output logic level
);
   localparam int CNT_W = (DB_LEN > 1) ? $clog2(DB_LEN) : 1;

   if (DB_LEN < 2) begin : g_bad_len
      $error("gpio_debounce: DB_LEN must be at least 2");
   end

   logic sample;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign sample = raw;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2+1-1:0], raw} >> 0;
      end
      assign sample = sync_q[SYNC_STAGES-1];
   end

   logic [CNT_W-1:0] cnt_q;
   logic             lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (tick) begin
         if (sample == lvl_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CNT_W'(DB_LEN - 1)) begin
            cnt_q <= '0;
            lvl_q <= sample;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign level = lvl_q;

   AST_DB_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(lvl_q)); // R7

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
   import gpio_bank_pkg::*;
(
   input  pin_cfg_t cfg,
   input  logic     lvl,
   output logic     pad_out,
   output logic     pad_oe,
   output logic     pad_pu,
   output logic     pad_pd
);
   logic target;
   logic active;

   always_comb begin
      target  = lvl ^ ~cfg.pol;
      active  = cfg.ena && !cfg.dir_in && (cfg.func == 4'h0);
      pad_out = active && !cfg.odrain && target;
      pad_oe  = active && (!cfg.odrain || !target);
      pad_pu  = (cfg.pull == PULL_UP);
      pad_pd  = (cfg.pull == PULL_DN);
   end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic both_edge,
   input  logic pol,
   input  logic clr,
   output logic sts
);
   logic prev_q;
   logic sts_q;
   logic rise;
   logic fall;
   logic fire;

   always_comb begin
      rise = level && !prev_q;
      fall = !level && prev_q;
      fire = both_edge ? (rise || fall) : (pol ? rise : fall);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         sts_q  <= 1'b0;
      end else begin
         prev_q <= level;
         if (fire)     sts_q <= 1'b1;
         else if (clr) sts_q <= 1'b0;
      end
   end

   assign sts = sts_q;

   AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q && !clr) |=> sts_q); // R10

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS    = 12,
   parameter int DATA_W      = 16,
   parameter int DB_LEN      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = $clog2(NUM_PINS + 2)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_tick,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu,
   output logic [NUM_PINS-1:0] pad_pd,
   output logic                irq
);
   localparam logic [ADDR_W-1:0] LVL_ADDR = ADDR_W'(NUM_PINS);
   localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(NUM_PINS + 1);

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_bank: NUM_PINS must be 1..DATA_W");
   end
   if (DATA_W < CFG_W) begin : g_bad_width
      $error("gpio_bank: DATA_W too narrow for a configuration word");
   end

   pin_cfg_t            cfg_q [NUM_PINS];
   logic [NUM_PINS-1:0] out_lvl_q;
   logic [NUM_PINS-1:0] db_lvl;
   logic [NUM_PINS-1:0] rd_lvl;
   logic [NUM_PINS-1:0] sts;
   logic [NUM_PINS-1:0] clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PINS; i++) cfg_q[i] <= CFG_RESET;
         out_lvl_q <= '0;
      end else if (reg_wr) begin
         for (int i = 0; i < NUM_PINS; i++) begin
            if (reg_addr == ADDR_W'(i)) cfg_q[i] <= pin_cfg_t'(reg_wdata[CFG_W-1:0]);
         end
         if (reg_addr == LVL_ADDR) out_lvl_q <= reg_wdata[NUM_PINS-1:0];
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      gpio_debounce #(.DB_LEN(DB_LEN), .SYNC_STAGES(SYNC_STAGES)) u_db (
         .clk   (clk),
         .rst_n (rst_n),
         .tick  (sample_tick),
         .raw   (pad_in[p]),
         .level (db_lvl[p])
      );

      gpio_pin_drive u_drv (
         .cfg     (cfg_q[p]),
         .lvl     (out_lvl_q[p]),
         .pad_out (pad_out[p]),
         .pad_oe  (pad_oe[p]),
         .pad_pu  (pad_pu[p]),
         .pad_pd  (pad_pd[p])
      );

      assign clr[p]    = reg_wr && (reg_addr == STS_ADDR) && reg_wdata[p];
      assign rd_lvl[p] = cfg_q[p].ena && (db_lvl[p] ^ ~cfg_q[p].pol);

      gpio_edge_irq u_irq (
         .clk       (clk),
         .rst_n     (rst_n),
         .level     (db_lvl[p]),
         .both_edge (cfg_q[p].both_edge),
         .pol       (cfg_q[p].pol),
         .clr       (clr[p]),
         .sts       (sts[p])
      );

      AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_q[p].dir_in || cfg_q[p].func != 4'h0) |-> !pad_oe[p]); // R3
      AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_q[p].odrain && pad_oe[p]) |-> !pad_out[p]); // R4
      AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
         !(pad_pu[p] && pad_pd[p])); // R5
      AST_TRISTATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg_q[p].ena |-> (!pad_oe[p] && !rd_lvl[p])); // R6
   end

   assign irq = |sts;

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (reg_addr == ADDR_W'(i)) reg_rdata = DATA_W'(cfg_q[i]);
      end
      if (reg_addr == LVL_ADDR) reg_rdata = DATA_W'(rd_lvl);
      if (reg_addr == STS_ADDR) reg_rdata = DATA_W'(sts);
   end

endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
   localparam int N  = 12;
   localparam int AW = $clog2(N + 2);
   localparam logic [AW-1:0] A_LVL = AW'(N);
   localparam logic [AW-1:0] A_STS = AW'(N + 1);

   logic          clk = 0;
   logic          rst_n = 0;
   logic          tick = 0;
   logic          reg_wr = 0;
   logic [AW-1:0] reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic [N-1:0]  pad_in, pad_out, pad_oe, pad_pu, pad_pd;
   logic          irq;
   logic [N-1:0]  ext_en = '0;
   logic [N-1:0]  ext_v  = '0;
   logic [N-1:0]  lvl_sh = '0;

   int checks = 0;
   int fails  = 0;
   int tcnt   = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      tcnt <= tcnt + 1;
      tick <= (tcnt % 2 == 0);
   end

   always_comb begin
      for (int i = 0; i < N; i++)
         pad_in[i] = pad_oe[i] ? pad_out[i] : ext_en[i] ? ext_v[i] : pad_pu[i];
   end

   gpio_bank u0 (
      .clk(clk), .rst_n(rst_n), .sample_tick(tick), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
      .pad_pd(pad_pd), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic settle();
      repeat (30) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      rd(0, d);        chk("R1 cfg pin1", d, 16'h0530);
      rd(AW'(N-1), d); chk("R1/R2 cfg pin12", d, 16'h0530);
      chk("R1 oe", pad_oe, '0);
      chk("R1 pd", pad_pd, {N{1'b1}});
      chk("R1 pu", pad_pu, '0);
      chk("R1 irq", irq, 0);
      rd(A_LVL, d);    chk("R1 level", d, 0);
   endtask

   task automatic t_pull();
      wr(2, 16'h0550); @(negedge clk);
      chk("R5 pull-up pu", pad_pu[2], 1); chk("R5 pull-up pd", pad_pd[2], 0);
      wr(2, 16'h0570); @(negedge clk);
      chk("R5 reserved", {pad_pu[2], pad_pd[2]}, 0);
      wr(2, 16'h0510); @(negedge clk);
      chk("R5 none", {pad_pu[2], pad_pd[2]}, 0);
   endtask

   task automatic t_output();
      logic [15:0] d;
      wr(3, 16'h0520);
      lvl_sh[3] = 1; wr(A_LVL, 16'(lvl_sh)); @(negedge clk);
      chk("R4 cmos oe", pad_oe[3], 1); chk("R4 cmos high", pad_out[3], 1);
      settle(); rd(A_LVL, d); chk("R8 out readback pol1", d[3], 1);
      wr(3, 16'h0420); @(negedge clk);
      chk("R4 inverted drive", pad_out[3], 0);
      settle(); rd(A_LVL, d); chk("R8 out readback pol0", d[3], 1);
      wr(3, 16'h0525); @(negedge clk);
      chk("R3 func nonzero", pad_oe[3], 0);
      wr(3, 16'h0530); @(negedge clk);
      chk("R3 input released", pad_oe[3], 0);
   endtask

   task automatic t_odrain();
      wr(4, 16'h0720);
      lvl_sh[4] = 0; wr(A_LVL, 16'(lvl_sh)); @(negedge clk);
      chk("R4 od low oe", pad_oe[4], 1); chk("R4 od low val", pad_out[4], 0);
      lvl_sh[4] = 1; wr(A_LVL, 16'(lvl_sh)); @(negedge clk);
      chk("R4 od release", pad_oe[4], 0);
   endtask

   task automatic t_enable();
      logic [15:0] d;
      ext_en[5] = 1; ext_v[5] = 1;
      wr(5, 16'h0120);
      lvl_sh[5] = 1; wr(A_LVL, 16'(lvl_sh)); @(negedge clk);
      chk("R6 tristate", pad_oe[5], 0);
      settle(); rd(A_LVL, d); chk("R6 readback zero", d[5], 0);
   endtask

   task automatic t_debounce();
      logic [15:0] d;
      ext_en[6] = 1; ext_v[6] = 1;
      repeat (5) @(negedge clk);
      ext_v[6] = 0;
      settle(); rd(A_LVL, d); chk("R7 short pulse ignored", d[6], 0);
      ext_v[6] = 1;
      repeat (3) @(negedge clk);
      rd(A_LVL, d); chk("R7 not yet accepted", d[6], 0);
      settle(); rd(A_LVL, d); chk("R7 long level accepted", d[6], 1);
   endtask

   task automatic t_irq();
      logic [15:0] d;
      ext_en[9:7] = '1; ext_v[9:7] = '0;
      wr(8, 16'h0430); wr(9, 16'h05B0);
      settle(); wr(A_STS, 16'hFFFF); @(negedge clk);
      chk("R10 cleared all", irq, 0);
      ext_v[7] = 1; settle();
      rd(A_STS, d); chk("R9 rise pol1", d[7], 1);
      chk("R10 irq or", irq, 1);
      wr(A_STS, 16'h0000); rd(A_STS, d); chk("R10 zero write keeps", d[7], 1);
      wr(A_STS, 16'h0080); @(negedge clk);
      chk("R10 w1c irq low", irq, 0);
      ext_v[7] = 0; settle();
      rd(A_STS, d); chk("R9 fall ignored pol1", d[7], 0);
      ext_v[8] = 1; settle();
      rd(A_STS, d); chk("R9 rise ignored pol0", d[8], 0);
      rd(A_LVL, d); chk("R8 input inverted", d[8], 0);
      ext_v[8] = 0; settle();
      rd(A_STS, d); chk("R9 fall pol0", d[8], 1);
      wr(A_STS, 16'h0100);
      ext_v[9] = 1; settle();
      rd(A_STS, d); chk("R9 both rise", d[9], 1);
      wr(A_STS, 16'h0200); @(negedge clk);
      ext_v[9] = 0; settle();
      rd(A_STS, d); chk("R9 both fall", d[9], 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_pull();
      t_output();
      t_odrain();
      t_enable();
      t_debounce();
      t_irq();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule